// File: doc/BRIEF.md
# Decode-Stage Data Hazard Stall Unit

This block decides, every cycle, whether the instruction in the decode stage of a five-stage in-order pipeline can go ahead. Operands are read from the register file in decode but written back only in the last stage. A young instruction can therefore name a register whose new value an older instruction has not yet written. The unit compares the two source register indices of the decode instruction with the destination index of each older instruction in execute, memory and write-back. It asserts a stall when the needed value cannot be delivered in time.

A stall raises three outputs together. One freezes the program counter. One holds the fetch/decode pipeline register. One turns the decode instruction into a bubble as it enters the decode/execute register. A static parameter picks the policy. The full-stall policy suits a datapath with no bypass paths. The load-use policy suits a datapath that bypasses ALU and write-back results, where only a load followed at once by a consumer has to wait. Register zero is never a hazard source. All outputs are combinational from the current pipeline-register fields.

Top module: `hazard_stall_unit`

## Requirements
- R1: With MODE = HZ_FULL_STALL, a stall is raised when source A is nonzero and equals the destination of an older stage in execute, memory or write-back whose write-enable is 1.
- R2: With MODE = HZ_FULL_STALL, the same test applies independently to source B, and either match alone stalls.
- R3: A source index of 0 never causes a stall in either mode, even when an older stage writes register 0.
- R4: An older stage whose write-enable is 0 (store, branch) never causes a stall, whatever its destination or load flag.
- R5: With MODE = HZ_LOAD_USE, a stall is raised exactly when the execute-stage instruction has write-enable 1 and load flag 1, and its destination equals a nonzero source of the decode instruction.
- R6: With MODE = HZ_LOAD_USE, a match against the memory or write-back stage, or against a non-load in execute, does not stall.
- R7: pc_hold, ifid_hold and idex_bubble are always equal to each other.
- R8: Outputs depend only on the current inputs, with no clock or stored state: a change in the inputs changes the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | IDX_W | Decode-stage source register A index |
| id_src_b | input | IDX_W | Decode-stage source register B index |
| ex_dst | input | IDX_W | Execute-stage destination index |
| ex_wr_en | input | 1 | Execute-stage register write-enable |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | IDX_W | Memory-stage destination index |
| mem_wr_en | input | 1 | Memory-stage register write-enable |
| wb_dst | input | IDX_W | Write-back-stage destination index |
| wb_wr_en | input | 1 | Write-back-stage register write-enable |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register contents |
| idex_bubble | output | 1 | Inject a nop into the decode/execute register |

## Verification
The hardest case to reach is a load-use hit in execute while the same register is also in flight in memory or write-back, with the other source at zero. Uniform random indices over 32 registers seldom line up three destinations. The random stimulus therefore draws indices from a four-register window, so that collisions, zero indices and repeated destinations are frequent. Both policies are instantiated side by side on the same inputs, and directed vectors pin down the zero-register and write-enable-off corners.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic {
    HZ_FULL_STALL = 1'b0,
    HZ_LOAD_USE   = 1'b1
  } hz_mode_e;

  // older stages compared against decode: 0 = execute, 1 = memory, 2 = write-back
  localparam int unsigned HZ_OLDER = 3;
  localparam int unsigned HZ_EX    = 0;

  // a nonzero source index equal to a written destination
  function automatic logic hz_dep(input logic [31:0] src,
                                  input logic [31:0] dst,
                                  input logic        wr);
    return wr && (src != 32'd0) && (src == dst);
  endfunction

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned N     = hz_pkg::HZ_OLDER
) (
  input  logic [IDX_W-1:0]        src,
  input  logic [N-1:0][IDX_W-1:0] dst,
  input  logic [N-1:0]            wr,
  output logic [N-1:0]            hit
);
  localparam int unsigned PAD = 32 - IDX_W;

  for (genvar s = 0; s < N; s++) begin : g_stage
    assign hit[s] = hz_pkg::hz_dep({{PAD{1'b0}}, src}, {{PAD{1'b0}}, dst[s]}, wr[s]);
  end

  // R3: a zero source never reports a hit
  always_comb begin
    if (!$isunknown(src)) begin
      a_r3_zero_no_hit: assert (src != '0 || hit == '0);
    end
  end

endmodule

// File: rtl/hz_stall_policy.sv
module hz_stall_policy #(
  parameter hz_pkg::hz_mode_e MODE = hz_pkg::HZ_FULL_STALL,
  parameter int unsigned      N    = hz_pkg::HZ_OLDER
) (
  input  logic [N-1:0] hit_a,
  input  logic [N-1:0] hit_b,
  input  logic         ex_load,
  output logic         full_req,
  output logic         lu_req,
  output logic         stall
);
  assign full_req = (|hit_a) | (|hit_b);
  assign lu_req   = ex_load & (hit_a[hz_pkg::HZ_EX] | hit_b[hz_pkg::HZ_EX]);
  assign stall    = (MODE == hz_pkg::HZ_LOAD_USE) ? lu_req : full_req;

  // R5: the load-use request needs an execute-stage hit
  always_comb begin
    if (!$isunknown({hit_a, hit_b, ex_load})) begin
      a_r5_lu_needs_ex_hit: assert (!lu_req || hit_a[hz_pkg::HZ_EX] || hit_b[hz_pkg::HZ_EX]);
    end
  end

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int unsigned      IDX_W = 5,
  parameter hz_pkg::hz_mode_e MODE  = hz_pkg::HZ_FULL_STALL
) (
  input  logic [IDX_W-1:0] id_src_a,
  input  logic [IDX_W-1:0] id_src_b,
  input  logic [IDX_W-1:0] ex_dst,
  input  logic             ex_wr_en,
  input  logic             ex_is_load,
  input  logic [IDX_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [IDX_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble
);
  localparam int unsigned N = hz_pkg::HZ_OLDER;

  logic [N-1:0][IDX_W-1:0] older_dst;
  logic [N-1:0]            older_wr;
  logic [N-1:0]            hit_a;
  logic [N-1:0]            hit_b;
  logic                    full_req;
  logic                    lu_req;
  logic                    stall;

  assign older_dst = {wb_dst, mem_dst, ex_dst};
  assign older_wr  = {wb_wr_en, mem_wr_en, ex_wr_en};

  hz_src_cmp #(.IDX_W(IDX_W), .N(N)) u_cmp_a (
    .src(id_src_a), .dst(older_dst), .wr(older_wr), .hit(hit_a)
  );

  hz_src_cmp #(.IDX_W(IDX_W), .N(N)) u_cmp_b (
    .src(id_src_b), .dst(older_dst), .wr(older_wr), .hit(hit_b)
  );

  hz_stall_policy #(.MODE(MODE), .N(N)) u_policy (
    .hit_a(hit_a), .hit_b(hit_b), .ex_load(ex_is_load),
    .full_req(full_req), .lu_req(lu_req), .stall(stall)
  );

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  always_comb begin
    if (!$isunknown({id_src_a, id_src_b, ex_dst, ex_wr_en, ex_is_load,
                     mem_dst, mem_wr_en, wb_dst, wb_wr_en})) begin
      a_r3_zero_sources: assert (!(id_src_a == '0 && id_src_b == '0) || !pc_hold);
      a_r4_no_writers: assert ((ex_wr_en || mem_wr_en || wb_wr_en) || !pc_hold);
      a_r7_outputs_agree: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
      if (MODE == hz_pkg::HZ_FULL_STALL) begin
        a_r1_src_a_match: assert (!(id_src_a != '0 && ex_wr_en && id_src_a == ex_dst) || pc_hold);
        a_r2_src_b_match: assert (!(id_src_b != '0 && wb_wr_en && id_src_b == wb_dst) || pc_hold);
      end else begin
        a_r6_load_in_ex_only: assert (!pc_hold || (ex_wr_en && ex_is_load));
      end
    end
  end

endmodule

// File: tb/hazard_stall_unit_tb_top.sv
module hazard_stall_unit_tb_top;
  localparam int unsigned W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] src_a, src_b, ex_d, mem_d, wb_d;
  logic         ex_w, ex_l, mem_w, wb_w;
  logic         f_pc, f_ifid, f_bub, l_pc, l_ifid, l_bub;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  hazard_stall_unit #(.IDX_W(W), .MODE(hz_pkg::HZ_FULL_STALL)) dut_i (
    .id_src_a(src_a), .id_src_b(src_b), .ex_dst(ex_d), .ex_wr_en(ex_w),
    .ex_is_load(ex_l), .mem_dst(mem_d), .mem_wr_en(mem_w), .wb_dst(wb_d),
    .wb_wr_en(wb_w), .pc_hold(f_pc), .ifid_hold(f_ifid), .idex_bubble(f_bub)
  );

  hazard_stall_unit #(.IDX_W(W), .MODE(hz_pkg::HZ_LOAD_USE)) dut_lu_i (
    .id_src_a(src_a), .id_src_b(src_b), .ex_dst(ex_d), .ex_wr_en(ex_w),
    .ex_is_load(ex_l), .mem_dst(mem_d), .mem_wr_en(mem_w), .wb_dst(wb_d),
    .wb_wr_en(wb_w), .pc_hold(l_pc), .ifid_hold(l_ifid), .idex_bubble(l_bub)
  );

  // reference: dependency on one older stage
  function automatic bit dep(input logic [W-1:0] s, input logic [W-1:0] d, input logic we);
    if (!we) return 1'b0;      // R4
    if (s == 0) return 1'b0;   // R3
    return s == d;
  endfunction

  function automatic bit exp_full();  // R1, R2
    return dep(src_a, ex_d, ex_w) || dep(src_a, mem_d, mem_w) || dep(src_a, wb_d, wb_w) ||
           dep(src_b, ex_d, ex_w) || dep(src_b, mem_d, mem_w) || dep(src_b, wb_d, wb_w);
  endfunction

  function automatic bit exp_lu();    // R5, R6
    return ex_l && (dep(src_a, ex_d, ex_w) || dep(src_b, ex_d, ex_w));
  endfunction

  task automatic check(input string req);
    bit ef, el;
    #1;  // R8: no clock edge between drive and sample
    ef = exp_full();
    el = exp_lu();
    vectors++;
    if ({f_pc, f_ifid, f_bub} != {3{ef}}) begin
      fails++;
      $display("FAIL %s full-stall: got %b%b%b expected %b%b%b", req, f_pc, f_ifid, f_bub, ef, ef, ef);
    end
    if ({l_pc, l_ifid, l_bub} != {3{el}}) begin
      fails++;
      $display("FAIL %s load-use: got %b%b%b expected %b%b%b", req, l_pc, l_ifid, l_bub, el, el, el);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] ed, input logic ew, input logic el,
                       input logic [W-1:0] md, input logic mw,
                       input logic [W-1:0] wd, input logic ww);
    @(negedge clk);
    src_a = a; src_b = b; ex_d = ed; ex_w = ew; ex_l = el;
    mem_d = md; mem_w = mw; wb_d = wd; wb_w = ww;
  endtask

  initial begin
    void'($urandom(32'd1234));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);      check("R7 idle");
    drive(3, 0, 3, 1, 0, 0, 0, 0, 0);      check("R1 ex");
    drive(3, 0, 0, 0, 0, 3, 1, 0, 0);      check("R1 mem");
    drive(3, 0, 0, 0, 0, 0, 0, 3, 1);      check("R1 wb");
    drive(0, 7, 0, 0, 0, 0, 0, 7, 1);      check("R2 wb");
    drive(1, 7, 7, 1, 1, 0, 0, 0, 0);      check("R2 R5 load src b");
    drive(0, 0, 0, 1, 1, 0, 1, 0, 1);      check("R3 zero all");
    drive(0, 9, 0, 1, 1, 0, 1, 0, 1);      check("R3 zero a");
    drive(4, 4, 4, 0, 1, 4, 0, 4, 0);      check("R4 we off");
    drive(5, 0, 5, 1, 1, 0, 0, 0, 0);      check("R5 load use");
    drive(5, 0, 5, 1, 0, 0, 0, 0, 0);      check("R6 ex alu");
    drive(5, 6, 1, 1, 1, 5, 1, 6, 1);      check("R6 mem wb");
    drive(5, 0, 5, 1, 1, 5, 1, 5, 1);      check("R5 triple");
    // R8: change inputs mid-cycle, no clock edge
    #2; src_a = 2; ex_d = 2; ex_w = 1; ex_l = 1; check("R8 comb");
    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1));
      check("R1 R2 R3 R4 R5 R6 R7 random");
    end
    for (int i = 0; i < 500; i++) begin
      drive($urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom);
      check("R1 R5 wide random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule